// File: doc/BRIEF.md
# Processor Reset and Strap Sequencer

This block drives the active-low reset of a host processor. The processor is held in reset while the asynchronous, active-low platform reset input is low. After the platform reset is released, the reset is held for a further programmable delay, counted in host clock cycles, before it is released. The nominal delay is one millisecond: 66,667 cycles at 66.67 MHz. A resume-from-suspend request can also put the processor through a reset. It does so only when the reset-on-resume enable bit is set, and it uses the same delay.

A second output, `strap_sel_n`, lags the processor reset by two host clocks. It steers an external multiplexer. While `strap_sel_n` is low, the multiplexer puts the processor clock-ratio strap values on the shared pins. Those values are therefore still present when the processor reset rises, and they stay there for two more host clocks. That lag must lie between 2 and 20 clocks. When the platform reset is released, the block also captures the bridge's own configuration straps, including a suspend-disable strap. It holds them on read-only outputs.

The platform reset is brought into the host clock domain through a two-flop synchronizer before its release edge is detected. Assertion of the platform reset clears the sequencer asynchronously, so no assertion can be missed.

Top module: `cpu_rst_seq`

## Requirements
- R1: While `plat_rst_n` is low, `proc_rst_n` is low. It goes low at once when `plat_rst_n` falls, without waiting for a clock edge.
- R2: After `plat_rst_n` rises between two clock edges, `proc_rst_n` goes high on the (DELAY+3)th rising `clk` edge after the release. This is two synchronizer edges, one detection edge and DELAY counting edges.
- R3: If `plat_rst_n` falls again before the count completes, the count is discarded and `proc_rst_n` stays low. Timing restarts from the next release and again takes DELAY+3 edges.
- R4: While the processor is running, a `resume_req` sampled high with `rst_on_resume` = 1 makes `proc_rst_n` go low at that same edge. `proc_rst_n` then stays low for exactly DELAY clock cycles before it rises.
- R5: A `resume_req` sampled with `rst_on_resume` = 0 has no effect, and `proc_rst_n` stays high.
- R6: `strap_sel_n` equals the value `proc_rst_n` had two clock edges earlier. The one exception is platform reset: while `plat_rst_n` is low, `strap_sel_n` is forced low at once.
- R7: `strap_cfg` and `sus_dis` take the values of `strap_in` and `sus_dis_in` at the third `clk` edge after the `plat_rst_n` release. They keep those values through later input changes and resume resets, until the next platform release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| plat_rst_n | input | 1 | Asynchronous active-low platform reset |
| resume_req | input | 1 | One-cycle resume-from-suspend request |
| rst_on_resume | input | 1 | Enable for a processor reset on resume |
| strap_in | input | STRAP_W | Bridge configuration strap pins |
| sus_dis_in | input | 1 | Suspend-disable strap pin |
| proc_rst_n | output | 1 | Active-low processor reset |
| strap_sel_n | output | 1 | Strap multiplexer select, reset lagged by two clocks |
| strap_cfg | output | STRAP_W | Latched configuration straps |
| sus_dis | output | 1 | Latched suspend-disable strap |

## Verification
Each result is due at a fixed cycle after its stimulus:
- **Platform release:** `proc_rst_n` rises DELAY+3 edges after the release, and `strap_sel_n` rises two edges after that.
- **Enabled resume:** `proc_rst_n` falls at the edge that samples the request and rises DELAY edges later. `strap_sel_n` follows two edges behind on both transitions.
- **Platform assertion:** both outputs fall with no clock edge involved.

The driver turns each stimulus into expected values stamped with absolute cycle numbers, including the cycle just before each transition. The monitor compares them one nanosecond after the matching rising edge. Captured straps are read after the inputs have been changed and after a resume reset has run.

// File: rtl/cpu_rst_pkg.sv
package cpu_rst_pkg;
  typedef enum logic [1:0] {
    SEQ_HOLD  = 2'd0,
    SEQ_COUNT = 2'd1,
    SEQ_RUN   = 2'd2
  } seq_state_e;
endpackage

// File: rtl/cpu_rst_sync.sv
module cpu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rel_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rel_o = chain_q[STAGES-1];

  // R1
  sync_low_in_reset_chk: assert property (@(posedge clk) !arst_n |-> !rel_o);
endmodule

// File: rtl/cpu_rst_timer.sv
module cpu_rst_timer
  import cpu_rst_pkg::*;
#(
  parameter int DELAY = 66667
) (
  input  logic clk,
  input  logic arst_n,
  input  logic start_i,
  input  logic resume_i,
  input  logic en_i,
  output logic run_o
);
  localparam int CW = (DELAY > 2) ? $clog2(DELAY) : 1;
  localparam logic [CW-1:0] LAST = CW'(DELAY - 1);

  seq_state_e    state_q;
  logic [CW-1:0] cnt_q;
  logic          restart;

  assign restart = resume_i & en_i;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      state_q <= SEQ_HOLD;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        SEQ_HOLD: begin
          cnt_q <= '0;
          if (start_i) state_q <= SEQ_COUNT;
        end
        SEQ_COUNT: begin
          if (restart) begin
            cnt_q <= '0;
          end else if (cnt_q == LAST) begin
            state_q <= SEQ_RUN;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        SEQ_RUN: begin
          if (restart) begin
            state_q <= SEQ_COUNT;
            cnt_q   <= '0;
          end
        end
        default: begin
          state_q <= SEQ_HOLD;
          cnt_q   <= '0;
        end
      endcase
    end
  end

  assign run_o = (state_q == SEQ_RUN);

  // R2
  count_in_range_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (state_q == SEQ_COUNT) |-> (cnt_q <= LAST));
  // R2
  run_only_after_count_chk: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(run_o) |-> ($past(state_q) == SEQ_COUNT && $past(cnt_q) == LAST));
  // R4
  resume_drops_run_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (run_o && resume_i && en_i) |=> !run_o);
  // R5
  resume_ignored_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (run_o && resume_i && !en_i) |=> run_o);
endmodule

// File: rtl/cpu_rst_lag.sv
module cpu_rst_lag #(
  parameter int LAG = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d_i,
  output logic q_o
);
  logic [LAG-1:0] pipe_q;

  generate
    for (genvar i = 0; i < LAG; i++) begin : g_stage
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) pipe_q[i] <= 1'b0;
        else if (i == 0) pipe_q[i] <= d_i;
        else pipe_q[i] <= pipe_q[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign q_o = pipe_q[LAG-1];

  // R6
  lag_follows_chk: assert property (@(posedge clk) disable iff (!arst_n)
    q_o |-> $past(d_i, LAG));
endmodule

// File: rtl/cpu_rst_seq.sv
module cpu_rst_seq #(
  parameter int DELAY   = 66667,
  parameter int SEL_LAG = 2,
  parameter int STRAP_W = 4
) (
  input  logic               clk,
  input  logic               plat_rst_n,
  input  logic               resume_req,
  input  logic               rst_on_resume,
  input  logic [STRAP_W-1:0] strap_in,
  input  logic               sus_dis_in,
  output logic               proc_rst_n,
  output logic               strap_sel_n,
  output logic [STRAP_W-1:0] strap_cfg,
  output logic               sus_dis
);
  logic rel, rel_d_q, rel_rise, run;

  initial begin
    if (SEL_LAG < 2 || SEL_LAG > 20) $error("SEL_LAG outside 2..20");
  end

  cpu_rst_sync #(.STAGES(2)) u_sync (
    .clk(clk), .arst_n(plat_rst_n), .rel_o(rel)
  );

  always_ff @(posedge clk or negedge plat_rst_n) begin
    if (!plat_rst_n) rel_d_q <= 1'b0;
    else             rel_d_q <= rel;
  end

  assign rel_rise = rel & ~rel_d_q;

  cpu_rst_timer #(.DELAY(DELAY)) u_timer (
    .clk(clk), .arst_n(plat_rst_n), .start_i(rel_rise),
    .resume_i(resume_req), .en_i(rst_on_resume), .run_o(run)
  );

  assign proc_rst_n = run;

  cpu_rst_lag #(.LAG(SEL_LAG)) u_lag (
    .clk(clk), .arst_n(plat_rst_n), .d_i(run), .q_o(strap_sel_n)
  );

  always_ff @(posedge clk) begin
    if (rel_rise) begin
      strap_cfg <= strap_in;
      sus_dis   <= sus_dis_in;
    end
  end

  // R1
  proc_low_in_reset_chk: assert property (@(posedge clk) !plat_rst_n |-> !proc_rst_n);
  // R6
  sel_low_in_reset_chk: assert property (@(posedge clk) !plat_rst_n |-> !strap_sel_n);
  // R7
  straps_hold_chk: assert property (@(posedge clk) disable iff (!plat_rst_n)
    (rel_d_q && !rel_rise) |=> ($stable(strap_cfg) && $stable(sus_dis)));
endmodule

// File: tb/cpu_rst_seq_tb_top.sv
module cpu_rst_seq_tb_top;
  localparam int DLY = 20;
  localparam int SW  = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          plat_rst_n = 1'b0;
  logic          resume_req = 1'b0;
  logic          rst_on_resume = 1'b0;
  logic [SW-1:0] strap_in = 4'hA;
  logic          sus_dis_in = 1'b1;
  logic          proc_rst_n, strap_sel_n, sus_dis;
  logic [SW-1:0] strap_cfg;

  cpu_rst_seq #(.DELAY(DLY), .SEL_LAG(2), .STRAP_W(SW)) dut_i (
    .clk(clk), .plat_rst_n(plat_rst_n), .resume_req(resume_req),
    .rst_on_resume(rst_on_resume), .strap_in(strap_in), .sus_dis_in(sus_dis_in),
    .proc_rst_n(proc_rst_n), .strap_sel_n(strap_sel_n),
    .strap_cfg(strap_cfg), .sus_dis(sus_dis)
  );

  typedef struct {
    int    cyc;
    logic  rst;
    logic  sel;
    string req;
  } exp_t;

  exp_t q[$];
  exp_t cur;
  int   cyc = 0;
  int   nrun = 0;
  int   nfail = 0;

  task automatic push(input int c, input logic r, input logic s, input string rq);
    exp_t e;
    e.cyc = c; e.rst = r; e.sel = s; e.req = rq;
    q.push_back(e);
  endtask

  task automatic chk(input bit ok, input string rq, input int got, input int exp);
    nrun++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s got %0h expected %0h", rq, got, exp);
    end
  endtask

  // monitor: compares expected items one ns after the matching edge
  always @(posedge clk) begin
    cyc++;
    #1;
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      cur = q.pop_front();
      nrun++;
      if (proc_rst_n !== cur.rst || strap_sel_n !== cur.sel) begin
        nfail++;
        $display("FAIL %s cycle %0d rst/sel got %b%b expected %b%b",
                 cur.req, cyc, proc_rst_n, strap_sel_n, cur.rst, cur.sel);
      end
    end
  end

  task automatic finish_run();
    if (q.size() != 0) begin
      nfail++;
      $display("FAIL scoreboard %0d items left, expected 0", q.size());
    end
    $display("  [TB] %0d tests run, %0d failed", nrun, nfail);
    $finish;
  endtask

  initial begin
    #800000;
    nfail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int b, b2;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(proc_rst_n === 1'b0, "R1 reset", proc_rst_n, 0);
    chk(strap_sel_n === 1'b0, "R6 reset", strap_sel_n, 0);

    // R2 release timing
    @(negedge clk); plat_rst_n = 1'b1; b = cyc;
    push(b + DLY + 2, 1'b0, 1'b0, "R2");
    push(b + DLY + 3, 1'b1, 1'b0, "R2");
    push(b + DLY + 4, 1'b1, 1'b0, "R6");
    push(b + DLY + 5, 1'b1, 1'b1, "R6");
    repeat (5) @(negedge clk);
    strap_in = 4'h5; sus_dis_in = 1'b0;
    repeat (DLY + 6) @(negedge clk);
    chk(strap_cfg === 4'hA, "R7 hold", strap_cfg, 4'hA);
    chk(sus_dis === 1'b1, "R7 hold sus", sus_dis, 1);

    // R5 resume with enable clear
    b = cyc;
    push(b + 1, 1'b1, 1'b1, "R5");
    push(b + 3, 1'b1, 1'b1, "R5");
    resume_req = 1'b1;
    @(negedge clk); resume_req = 1'b0;
    repeat (5) @(negedge clk);

    // R4 resume with enable set
    rst_on_resume = 1'b1;
    b = cyc;
    push(b + 1, 1'b0, 1'b1, "R4");
    push(b + 2, 1'b0, 1'b1, "R6");
    push(b + 3, 1'b0, 1'b0, "R6");
    push(b + DLY, 1'b0, 1'b0, "R4");
    push(b + DLY + 1, 1'b1, 1'b0, "R4");
    push(b + DLY + 2, 1'b1, 1'b0, "R6");
    push(b + DLY + 3, 1'b1, 1'b1, "R6");
    resume_req = 1'b1;
    @(negedge clk); resume_req = 1'b0;
    repeat (DLY + 6) @(negedge clk);
    chk(strap_cfg === 4'hA, "R7 after resume", strap_cfg, 4'hA);

    // R1 / R6 asynchronous assertion while running
    plat_rst_n = 1'b0;
    #1;
    chk(proc_rst_n === 1'b0, "R1 async", proc_rst_n, 0);
    chk(strap_sel_n === 1'b0, "R6 async", strap_sel_n, 0);

    // R3 reassert mid-count
    strap_in = 4'h3; sus_dis_in = 1'b0;
    repeat (3) @(negedge clk);
    plat_rst_n = 1'b1; b = cyc;
    push(b + DLY + 3, 1'b0, 1'b0, "R3");
    repeat (10) @(negedge clk);
    plat_rst_n = 1'b0;
    #1;
    chk(proc_rst_n === 1'b0, "R3 reassert", proc_rst_n, 0);
    repeat (2) @(negedge clk);
    strap_in = 4'hC; sus_dis_in = 1'b1;
    plat_rst_n = 1'b1; b2 = cyc;
    push(b2 + DLY + 2, 1'b0, 1'b0, "R3");
    push(b2 + DLY + 3, 1'b1, 1'b0, "R3");
    repeat (4) @(negedge clk);
    strap_in = 4'h0; sus_dis_in = 1'b0;
    repeat (DLY + 6) @(negedge clk);
    chk(strap_cfg === 4'hC, "R7 recapture", strap_cfg, 4'hC);
    chk(sus_dis === 1'b1, "R7 recapture sus", sus_dis, 1);
    chk(proc_rst_n === 1'b1, "R2 running", proc_rst_n, 1);
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule